// File: doc/BRIEF.md
# Edge/Level Pin Interrupt Detector

This block watches the eight pins of a general-purpose port and turns chosen pin activity into interrupts. Each pin is set to edge or level triggering. It has two enables. One covers a falling edge or a low level. The other covers a rising edge or a high level. An edge-triggered pin can also be filtered. When filtering is on, a change counts only once the new level has been confirmed on two debounce sample strobes in a row. The strobe comes from outside the block, so the debounce rate is set by whoever drives it.

Each detected event sets a sticky per-pin source flag. The flags read directly on an output bus. Software clears them by writing ones on the clear port. The interrupt request is high while any flag is set. The wakeup output reports, in the same cycle, that an enabled event condition is present on some pin. The pin inputs must already be synchronised to the clock.

Top module: `pin_irq_detector`

## Requirements
- R1: While reset is low, and on the first cycle after it, `flag_q` reads 0 and `irq` is low.
- R2: A pin whose `trig_level` bit is 1 is level-triggered. A low level with its `fall_low_en` bit set, or a high level with its `rise_high_en` bit set, sets its flag at the next clock edge. The flag sets again on every edge while that level persists, so a clear only sticks once the level has gone.
- R3: A pin whose `trig_level` bit is 0 is edge-triggered. With debounce off, a 0-to-1 change sets the flag at the first clock edge that sees the new level, provided `rise_high_en` is set. A 1-to-0 change behaves the same way with `fall_low_en`.
- R4: An edge of one polarity does not set the flag when only the other polarity's enable is set for that pin.
- R5: On an edge-triggered pin with its `dbnc_en` bit set, a change counts only when the new level is sampled on two consecutive `dbnc_tick` strobes. The flag sets at the clock edge of the second strobe. A level seen on only one strobe raises nothing.
- R6: `dbnc_en` has no effect on a level-triggered pin. Such a pin still sets its flag one clock after the enabled level appears, with no strobe.
- R7: With `clr_we` high, each 1 in `clr_data` clears that flag at the next edge. A 0 bit leaves its flag unchanged. Flags do not change without an event or a clear.
- R8: If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R9: `irq` is high exactly when at least one flag is set, and it rises only after an event.
- R10: `wake` is high, combinationally, in any cycle in which an enabled event condition is present on at least one pin.
- R11: A pin level that is already present when reset is released is not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | 8 | Synchronised pin levels |
| trig_level | input | 8 | Per pin: 0 = edge-triggered, 1 = level-triggered |
| fall_low_en | input | 8 | Per pin enable for falling edge / low level |
| rise_high_en | input | 8 | Per pin enable for rising edge / high level |
| dbnc_en | input | 8 | Per pin debounce enable, edge mode only |
| dbnc_tick | input | 1 | One-cycle debounce sample strobe |
| clr_we | input | 1 | Flag clear write strobe |
| clr_data | input | 8 | Write-1-to-clear mask for the flags |
| flag_q | output | 8 | Sticky per-pin source flags |
| irq | output | 1 | OR of all source flags |
| wake | output | 1 | An enabled event condition is present now |

## Verification
The bench goes after the debounce filter with a pulse that spans only one strobe. A filter that commits on a single sample would raise a flag there. It also checks a real change held between strobes, where a filter that counts clock cycles instead of strobes would fire early. A clear is issued while a level condition is still present, so a design that gives the clear priority would lose the flag. A second clear follows once the level has gone, and a flag that fails to drop there shows the clear is broken. Finally, pins are held high through reset release with every edge enable on. An edge reference register that resets to zero would report a false rising edge at that point.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the pin interrupt detector.
// Assumes: one trigger-mode bit per pin, encoded as below.
package pin_irq_pkg;
    localparam int unsigned PIN_CNT_DEF = 8;
    localparam int unsigned CONFIRM_DEF = 2;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/pin_debouncer.sv
// Per-pin debounce filter. It keeps a confirmed level and counts strobes on
// which the pin differs from that level. When CONFIRM consecutive strobes
// disagree, it raises `commit` for that cycle and takes the new level.
// Assumes: `load` is high for one cycle after reset to prime the level.
module pin_debouncer #(
    parameter int unsigned CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sample_tick,
    input  logic pin,
    output logic commit
);
    localparam int unsigned CW = $clog2(CONFIRM + 1);

    logic          stable_q;
    logic [CW-1:0] agree_cnt;
    logic          differs;

    assign differs = (pin != stable_q);
    assign commit  = !load && sample_tick && differs
                     && (agree_cnt == CW'(CONFIRM - 1));

    // Track the confirmed level and the run of disagreeing strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q  <= 1'b0;
            agree_cnt <= '0;
        end else if (load) begin
            stable_q  <= pin;
            agree_cnt <= '0;
        end else if (sample_tick) begin
            if (!differs) begin
                agree_cnt <= '0;
            end else if (commit) begin
                stable_q  <= pin;
                agree_cnt <= '0;
            end else begin
                agree_cnt <= agree_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pin_event_sel.sv
// Per-pin event decision. Level mode compares the live level with the
// enables. Edge mode uses either the raw change against the previous sample
// or the debounce commit pulse, as chosen by the debounce enable.
// Assumes: `primed` is low only on the first cycle after reset.
module pin_event_sel
    import pin_irq_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       dbnc_on,
    input  logic       lo_en,
    input  logic       hi_en,
    input  logic       pin,
    input  logic       pin_prev,
    input  logic       primed,
    input  logic       db_commit,
    output logic       evt
);
    logic polarity_ok;
    logic raw_edge;

    // Pick the event source for this pin.
    always_comb begin
        polarity_ok = (pin && hi_en) || (!pin && lo_en);
        raw_edge    = primed && (pin != pin_prev);
        if (mode == TRIG_LEVEL) begin
            evt = polarity_ok;
        end else if (dbnc_on) begin
            evt = primed && db_commit && polarity_ok;
        end else begin
            evt = raw_edge && polarity_ok;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Sticky source flags. A new event sets a flag, and a write-1 mask clears it.
// If both hit one flag in the same cycle, the event wins.
// Assumes: the set vector is already qualified by the enables.
module irq_flag_bank #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flag_q
);
    logic [WIDTH-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_vec : '0;

    // Apply the clear first, then OR in the events so they take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | set_vec;
        end
    end
endmodule

// File: rtl/pin_irq_detector.sv
// Pin interrupt detector for one port. Edge or level triggering is chosen
// per pin, edges can be debounced on an external strobe, flags are sticky
// and clear on write-1, and `irq` and `wake` summarise the pins.
// Assumes: pin_lvl is already synchronised to clk.
module pin_irq_detector
    import pin_irq_pkg::*;
#(
    parameter int unsigned PIN_CNT = PIN_CNT_DEF,
    parameter int unsigned CONFIRM = CONFIRM_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_CNT-1:0] pin_lvl,
    input  logic [PIN_CNT-1:0] trig_level,
    input  logic [PIN_CNT-1:0] fall_low_en,
    input  logic [PIN_CNT-1:0] rise_high_en,
    input  logic [PIN_CNT-1:0] dbnc_en,
    input  logic               dbnc_tick,
    input  logic               clr_we,
    input  logic [PIN_CNT-1:0] clr_data,
    output logic [PIN_CNT-1:0] flag_q,
    output logic               irq,
    output logic               wake
);
    logic [PIN_CNT-1:0] pin_prev;
    logic               primed;
    logic [PIN_CNT-1:0] db_commit;
    logic [PIN_CNT-1:0] evt;

    // Keep the previous sample for edge detection and mark when it is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= '0;
            primed   <= 1'b0;
        end else begin
            pin_prev <= pin_lvl;
            primed   <= 1'b1;
        end
    end

    for (genvar g = 0; g < PIN_CNT; g++) begin : g_pin
        pin_debouncer #(
            .CONFIRM (CONFIRM)
        ) dbnc_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .load        (!primed),
            .sample_tick (dbnc_tick),
            .pin         (pin_lvl[g]),
            .commit      (db_commit[g])
        );

        pin_event_sel sel_i (
            .mode      (trig_mode_e'(trig_level[g])),
            .dbnc_on   (dbnc_en[g]),
            .lo_en     (fall_low_en[g]),
            .hi_en     (rise_high_en[g]),
            .pin       (pin_lvl[g]),
            .pin_prev  (pin_prev[g]),
            .primed    (primed),
            .db_commit (db_commit[g]),
            .evt       (evt[g])
        );
    end

    irq_flag_bank #(
        .WIDTH (PIN_CNT)
    ) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt),
        .clr_we  (clr_we),
        .clr_vec (clr_data),
        .flag_q  (flag_q)
    );

    assign irq  = |flag_q;
    assign wake = |evt;
endmodule

// File: rtl/pin_irq_detector_chk.sv
// Port-level properties of the pin interrupt detector, bound to the top.
module pin_irq_detector_chk #(
    parameter int unsigned PIN_CNT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dbnc_tick,
    input logic [PIN_CNT-1:0] trig_level,
    input logic [PIN_CNT-1:0] dbnc_en,
    input logic               clr_we,
    input logic [PIN_CNT-1:0] clr_data,
    input logic [PIN_CNT-1:0] flag_q,
    input logic               irq,
    input logic               wake
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0 && !irq));

    p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !wake) |=> ((flag_q & $past(clr_data)) == '0));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !wake) |=> (flag_q == $past(flag_q)));

    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> irq);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wake));

    p_dbnc_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_level == '0 && (&dbnc_en) && wake) |-> dbnc_tick);
endmodule

bind pin_irq_detector pin_irq_detector_chk #(
    .PIN_CNT (PIN_CNT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbnc_tick  (dbnc_tick),
    .trig_level (trig_level),
    .dbnc_en    (dbnc_en),
    .clr_we     (clr_we),
    .clr_data   (clr_data),
    .flag_q     (flag_q),
    .irq        (irq),
    .wake       (wake)
);

// File: tb/pin_irq_detector_tb_top.sv
module pin_irq_detector_tb_top;
    localparam time CLK_PERIOD = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_lvl = 8'hA5;
    logic [7:0] trig_level = '0;
    logic [7:0] fall_low_en = '0;
    logic [7:0] rise_high_en = '0;
    logic [7:0] dbnc_en = '0;
    logic       dbnc_tick = 1'b0;
    logic       clr_we = 1'b0;
    logic [7:0] clr_data = '0;
    logic [7:0] flag_q;
    logic       irq;
    logic       wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pin_irq_detector dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_lvl      (pin_lvl),
        .trig_level   (trig_level),
        .fall_low_en  (fall_low_en),
        .rise_high_en (rise_high_en),
        .dbnc_en      (dbnc_en),
        .dbnc_tick    (dbnc_tick),
        .clr_we       (clr_we),
        .clr_data     (clr_data),
        .flag_q       (flag_q),
        .irq          (irq),
        .wake         (wake)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flags(input logic [7:0] mask);
        clr_we = 1'b1; clr_data = mask;
        cyc();
        clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic tick_once();
        dbnc_tick = 1'b1;
        cyc();
        dbnc_tick = 1'b0;
    endtask

    // Reset state and no false edge at reset release (R1, R11).
    task automatic t_reset();
        cyc(3);
        check("R1 flags in reset", flag_q, 8'h00);
        check("R1 irq in reset", {7'd0, irq}, 8'h00);
        rise_high_en = 8'hFF; fall_low_en = 8'hFF;
        rst_n = 1'b1;
        cyc();
        check("R1 flags after release", flag_q, 8'h00);
        cyc(2);
        check("R11 no edge at release", flag_q, 8'h00);
        check("R11 no wake at release", {7'd0, wake}, 8'h00);
        rise_high_en = '0; fall_low_en = '0;
        pin_lvl = 8'h00;
        cyc(2);
    endtask

    // Raw edges, polarity selection and write-1-to-clear (R3, R4, R7, R9, R10).
    task automatic t_edges();
        rise_high_en = 8'h01;
        pin_lvl = 8'h01;
        #1 check("R10 wake on rising edge", {7'd0, wake}, 8'h01);
        cyc();
        check("R3 rising edge flag", flag_q, 8'h01);
        check("R9 irq with flag", {7'd0, irq}, 8'h01);
        cyc();
        check("R10 wake only on edge cycle", {7'd0, wake}, 8'h00);
        clear_flags(8'h01);
        check("R7 clear by 1", flag_q, 8'h00);
        check("R9 irq drops", {7'd0, irq}, 8'h00);
        fall_low_en = 8'h02;
        pin_lvl = 8'h03;
        cyc();
        check("R4 rising ignored when only falling enabled", flag_q, 8'h00);
        pin_lvl = 8'h01;
        cyc();
        check("R3 falling edge flag", flag_q, 8'h02);
        clear_flags(8'hFD);
        check("R7 zero bits leave flag", flag_q, 8'h02);
        clear_flags(8'h02);
        check("R7 clear falling flag", flag_q, 8'h00);
        rise_high_en = '0; fall_low_en = '0;
        pin_lvl = 8'h00;
        cyc();
    endtask

    // Level triggering, re-set while present, and event-over-clear (R2, R6, R8).
    task automatic t_levels();
        trig_level = 8'h04; fall_low_en = 8'h04;
        cyc();
        check("R2 low level flag", flag_q, 8'h04);
        clear_flags(8'h04);
        check("R8 clear loses to present level", flag_q, 8'h04);
        pin_lvl = 8'h04;
        clear_flags(8'h04);
        check("R2 clear sticks after level gone", flag_q, 8'h00);
        trig_level = 8'h14; dbnc_en = 8'h10; rise_high_en = 8'h10;
        fall_low_en = '0;
        pin_lvl = 8'h14;
        cyc();
        check("R6 level with debounce bit, no strobe", flag_q, 8'h10);
        rise_high_en = '0; trig_level = '0; dbnc_en = '0;
        clear_flags(8'h10);
        check("R7 clear level flag", flag_q, 8'h00);
        pin_lvl = 8'h00;
        cyc();
        tick_once(); cyc(); tick_once(); cyc();
    endtask

    // Debounced edges: one-strobe glitch rejected, two strobes accepted (R5).
    task automatic t_debounce();
        dbnc_en = 8'h20; rise_high_en = 8'h20; fall_low_en = 8'h20;
        pin_lvl = 8'h20;
        cyc();
        tick_once();
        pin_lvl = 8'h00;
        cyc();
        tick_once();
        cyc(2);
        check("R5 one-strobe glitch rejected", flag_q, 8'h00);
        pin_lvl = 8'h20;
        cyc();
        tick_once();
        cyc(3);
        check("R5 no flag after one strobe", flag_q, 8'h00);
        dbnc_tick = 1'b1;
        #1 check("R5 wake on second strobe", {7'd0, wake}, 8'h01);
        cyc();
        dbnc_tick = 1'b0;
        check("R5 debounced rising flag", flag_q, 8'h20);
        clear_flags(8'h20);
        pin_lvl = 8'h00;
        cyc();
        tick_once();
        check("R5 falling waits for second strobe", flag_q, 8'h00);
        tick_once();
        check("R5 debounced falling flag", flag_q, 8'h20);
        dbnc_en = '0; rise_high_en = '0; fall_low_en = '0;
    endtask

    initial begin
        t_reset();
        t_edges();
        t_levels();
        t_debounce();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule